// File: doc/BRIEF.md
# DC-Blocking Highpass with Offset Freeze

This block strips the DC offset from a stream of 24-bit signed audio samples. It keeps a running estimate of the offset in a first-order leaky integrator and subtracts the integer part of that estimate from each incoming sample. The integrator moves toward the sample by a power-of-two fraction of the gap, so the -3 dB corner sits at a fixed fraction of the sample rate. It therefore scales in hertz with the speed mode, and the settling time in seconds shrinks by the same factor.

The tracking input is active low. While it is low, every valid sample updates the estimate. While it is high, the estimate is held but is still subtracted from every sample. Disabling the filter is therefore not a bypass. A system can let the filter settle on a quiet input and then raise the input to lock in a one-time calibration. The speed-mode code selects the coefficient shift from a per-mode table parameter. Its default gives every mode the same shift. The corrected result saturates to the 24-bit two's complement range.

Top module: `dcTrimFilter`

## Requirements
- R1: After reset `outValid` is 0, `outSample` is 0 and the offset estimate is zero, so the first sample after reset leaves the block unchanged.
- R2: `outValid` is high for exactly the cycle after each cycle with `inValid` high. `outSample` changes only in such a cycle and holds its value otherwise.
- R3: For each valid sample x, the output is sat(x - floor(A / 2^F)), where A is the accumulator before the update and F = MAX_SHIFT = 12.
- R4: When `trackN` is 0 at a valid sample, the accumulator is updated as A' = A + floor((x*2^F - A) / 2^s), where s is the shift for the current mode.
- R5: When `trackN` is 1 at a valid sample, A is held and the frozen estimate is still subtracted. Equal inputs then give equal outputs.
- R6: `speedMode` (0 = single, 1 = double, 2 = quad, 3 = octal speed) selects s from a table. By default s = 6 in every mode, so the same sample sequence gives the same outputs in every mode.
- R7: The result saturates to [-8388608, 8388607] and never wraps.
- R8: A constant input with tracking on converges: after 1500 samples the output magnitude is at most 1.
- R9: While `inValid` is 0, `inSample`, `trackN` and `speedMode` are ignored and the accumulator does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample strobe |
| inSample | input | 24 | Signed input sample |
| trackN | input | 1 | 0 = track the offset, 1 = freeze the offset |
| speedMode | input | 2 | Speed-mode code that selects the coefficient shift |
| outValid | output | 1 | Corrected-sample strobe, one cycle after `inValid` |
| outSample | output | 24 | Offset-corrected, saturated sample |

## Verification
The hardest condition to reach from the ports is saturation. An extreme sample only clips once the stored offset is large and has the sign opposite to that sample. The stimulus reaches this condition by tracking a long constant run (+1000, and later -50000) until the estimate settles. It then freezes the estimate and applies the full-scale value of the opposite sign. Constrained random samples in all speed modes are mixed with the directed runs. Idle gaps with toggling inputs show that only strobed samples move the estimate.

// File: rtl/hpfPkg.sv
package hpfPkg;
  localparam int SHIFT_W = 5;

  typedef struct packed {
    logic                 load;   // take a sample this cycle
    logic                 track;  // also update the offset estimate
    logic [SHIFT_W-1:0]   shift;  // coefficient shift for this sample
  } hpfStrobe_t;
endpackage

// File: rtl/hpfCtrl.sv
module hpfCtrl
  import hpfPkg::*;
#(
  parameter int MODES = 4,
  parameter int MAX_SHIFT = 12,
  parameter logic [MODES*SHIFT_W-1:0] MODE_SHIFTS = {MODES{5'd6}},
  localparam int MODE_W = $clog2(MODES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              trackN,
  input  logic [MODE_W-1:0] speedMode,
  output hpfStrobe_t        strobes
);
  logic [SHIFT_W-1:0] shiftTable [MODES];

  for (genvar m = 0; m < MODES; m++) begin : g_table
    assign shiftTable[m] = MODE_SHIFTS[m*SHIFT_W +: SHIFT_W];
  end

  always_comb begin
    strobes.load  = inValid;
    strobes.track = inValid & ~trackN;
    strobes.shift = shiftTable[speedMode];
  end

  // R6: every shift used for a sample leaves room in the fractional bits
  a_r6_shift_legal: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |-> (int'(strobes.shift) <= MAX_SHIFT));
endmodule

// File: rtl/hpfDatapath.sv
module hpfDatapath
  import hpfPkg::*;
#(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 12,
  localparam int ACC_W = DATA_W + FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  hpfStrobe_t        strobes,
  input  logic [DATA_W-1:0] inSample,
  output logic              outValid,
  output logic [DATA_W-1:0] outSample
);
  logic signed [ACC_W-1:0]  accQ;
  logic signed [ACC_W-1:0]  xScaled;
  logic signed [ACC_W:0]    deltaW;
  logic signed [ACC_W:0]    stepW;
  logic signed [ACC_W-1:0]  accNext;
  logic signed [DATA_W:0]   offsetEst;
  logic signed [DATA_W+1:0] diffW;
  logic [DATA_W-1:0]        satVal;
  logic                     inRange;

  always_comb begin
    xScaled   = {inSample[DATA_W-1], inSample, {FRAC_W{1'b0}}};
    deltaW    = {xScaled[ACC_W-1], xScaled} - {accQ[ACC_W-1], accQ};
    stepW     = deltaW >>> strobes.shift;
    accNext   = accQ + stepW[ACC_W-1:0];
    offsetEst = accQ[ACC_W-1:FRAC_W];
    diffW     = {{2{inSample[DATA_W-1]}}, inSample} - {offsetEst[DATA_W], offsetEst};
    inRange   = (diffW[DATA_W+1:DATA_W-1] == 3'b000) || (diffW[DATA_W+1:DATA_W-1] == 3'b111);
    if (inRange)               satVal = diffW[DATA_W-1:0];
    else if (diffW[DATA_W+1])  satVal = {1'b1, {(DATA_W-1){1'b0}}};
    else                       satVal = {1'b0, {(DATA_W-1){1'b1}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ      <= '0;
      outValid  <= 1'b0;
      outSample <= '0;
    end else begin
      outValid <= strobes.load;
      if (strobes.load) outSample <= satVal;
      if (strobes.track) accQ <= accNext;
    end
  end

  // R2: output strobe follows the input strobe by one cycle
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> outValid);
  a_r2_valid_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> (!outValid && $stable(outSample)));
  // R5 and R9: without a tracking strobe the estimate does not move
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.track |=> $stable(accQ));
  // R4: an update never moves the estimate away from the sample
  a_r4_toward_up: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.track && (xScaled >= accQ)) |=> (accQ >= $past(accQ)));
  a_r4_toward_down: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.track && (xScaled <= accQ)) |=> (accQ <= $past(accQ)));
  // R7: results beyond the range clip to the limits
  a_r7_clip_high: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !diffW[DATA_W+1] && diffW[DATA_W-1]) |=>
      (outSample == {1'b0, {(DATA_W-1){1'b1}}}));
  a_r7_clip_low: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && diffW[DATA_W+1] && !diffW[DATA_W-1]) |=>
      (outSample == {1'b1, {(DATA_W-1){1'b0}}}));
endmodule

// File: rtl/dcTrimFilter.sv
module dcTrimFilter
  import hpfPkg::*;
#(
  parameter int DATA_W = 24,
  parameter int MODES = 4,
  parameter int MAX_SHIFT = 12,
  parameter logic [MODES*SHIFT_W-1:0] MODE_SHIFTS = {MODES{5'd6}},
  localparam int MODE_W = $clog2(MODES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inSample,
  input  logic              trackN,
  input  logic [MODE_W-1:0] speedMode,
  output logic              outValid,
  output logic [DATA_W-1:0] outSample
);
  hpfStrobe_t strobes;

  hpfCtrl #(.MODES(MODES), .MAX_SHIFT(MAX_SHIFT), .MODE_SHIFTS(MODE_SHIFTS)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .trackN(trackN),
    .speedMode(speedMode), .strobes(strobes)
  );

  hpfDatapath #(.DATA_W(DATA_W), .FRAC_W(MAX_SHIFT)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inSample(inSample),
    .outValid(outValid), .outSample(outSample)
  );
endmodule

// File: tb/dcTrimFilter_test.sv
module dcTrimFilter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [23:0] inSample = '0;
  logic        trackN = 1'b0;
  logic [1:0]  speedMode = '0;
  logic        outValid;
  logic [23:0] outSample;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  longint accM = 0;
  localparam int F = 12;
  localparam int S = 6;

  always #10 clk = ~clk;

  dcTrimFilter uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .trackN(trackN), .speedMode(speedMode), .outValid(outValid), .outSample(outSample)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint satM(longint v);
    if (v > 8388607) return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction

  function automatic longint outSigned();
    return longint'($signed(outSample));
  endfunction

  // Drive one sample at a falling edge, check the result at the next one.
  task automatic sendSample(longint x, bit trk, logic [1:0] md, string req, output longint got);
    longint expOut;
    inValid = 1'b1; inSample = x[23:0]; trackN = trk; speedMode = md;
    expOut = satM(x - (accM >>> F));
    if (!trk) accM = accM + (((x <<< F) - accM) >>> S);
    @(negedge clk);
    inValid = 1'b0;
    got = outSigned();
    check(outValid == 1'b1, {req, " outValid"}, longint'(outValid), 1);
    check(got == expOut, req, got, expOut);
  endtask

  task automatic idleCycles(int n);
    logic [23:0] held;
    held = outSample;
    for (int i = 0; i < n; i++) begin
      inSample = 24'($urandom); trackN = 1'($urandom); speedMode = 2'($urandom);
      @(negedge clk);
      check(outValid == 1'b0, "R2 idle outValid", longint'(outValid), 0);
      check(outSample == held, "R2 idle hold", longint'(outSample), longint'(held));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint got;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 reset outValid", longint'(outValid), 0);
    check(outSample == '0, "R1 reset outSample", outSigned(), 0);

    // R1: zero estimate, first sample passes unchanged
    sendSample(5000, 1'b0, 2'd0, "R1 first sample", got);

    // R3 R4 R6: random samples in random modes, back to back
    for (int i = 0; i < 300; i++) begin
      longint x;
      x = longint'($signed(24'($urandom)));
      sendSample(x, 1'b0, 2'($urandom), "R3 R4 R6 random track", got);
      if (i % 50 == 0) idleCycles(2);
    end

    // R9: inputs toggle while no strobe; next sample must match model
    idleCycles(6);
    sendSample(1234, 1'b0, 2'd2, "R9 ignored idle inputs", got);

    // R8: constant input converges
    for (int i = 0; i < 1500; i++) sendSample(1000, 1'b0, 2'(i % 4), "R8 settle", got);
    check(got <= 1 && got >= -1, "R8 residual", got, 0);

    // R5: freeze, estimate held and still subtracted
    begin
      longint a, b;
      sendSample(777, 1'b1, 2'd1, "R5 frozen", a);
      sendSample(-300000, 1'b1, 2'd3, "R5 frozen", got);
      sendSample(777, 1'b1, 2'd0, "R5 frozen", b);
      check(a == b, "R5 same input same output", b, a);
    end

    // R7: negative clip with positive stored offset
    sendSample(-8388608, 1'b1, 2'd0, "R7 clip low", got);
    check(got == -8388608, "R7 clip low value", got, -8388608);

    // R7: positive clip with negative stored offset
    for (int i = 0; i < 1500; i++) sendSample(-50000, 1'b0, 2'(i % 4), "R8 settle neg", got);
    sendSample(8388607, 1'b1, 2'd3, "R7 clip high", got);
    check(got == 8388607, "R7 clip high value", got, 8388607);

    // R6: same frozen state, every mode gives the same result
    for (int m = 0; m < 4; m++) sendSample(4242, 1'b1, 2'(m), "R6 mode invariant", got);

    idleCycles(3);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule